// File: doc/BRIEF.md
# Fine-grained thread select scheduler

This block picks, on every clock, which of several hardware threads a single-issue in-order pipeline fetches and issues from. Fetch and select are tied together: the thread shown on the one-hot select output in a cycle is the thread fetched in that cycle. The pipeline may move to a different thread every cycle. A thread sitting out a long-latency delay is passed over, and so is a thread waiting for a cache refill, so that the other threads fill the gap.

Each thread reports a ready flag. It also has a pair of pulses that open and close its cache-miss wait. The pipeline returns one flag, in the same cycle as the select output, that says whether the instruction just issued for the shown thread is a load or a branch. Such an instruction blocks that thread for a fixed number of following cycles. Among the threads that may go, the one selected least recently wins. The select output and the valid bit are registered, so a change on the inputs in cycle t shows on the outputs in cycle t+1.

Top module: `thread_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, `sel_valid` is 0 and `sel_oh` is all zeros. Reset clears every block and every miss wait, and sets the age order to thread 0 oldest through thread 3 newest. With all threads ready after reset, thread 0 is selected first.
- R2: `sel_oh` has at most one bit set. `sel_valid` is 1 exactly when one bit is set. Bit i means thread i. The outputs show the pick made from the inputs of the previous cycle.
- R3: A thread whose `thr_ready` bit is 0 in cycle t is not shown on `sel_oh` in cycle t+1.
- R4: A `miss_start` pulse for thread i in cycle t opens its miss wait. Thread i is not shown from cycle t+1 until the cycle after it gets a `miss_done` pulse. If both pulses arrive in the same cycle, the start wins.
- R5: If `issue_long` is 1 in a cycle where thread i is shown on `sel_oh`, thread i is not shown in the next 3 cycles (parameter BLOCK_CYC). It may be shown again in the 4th.
- R6: Among the threads that may be selected, the one selected least recently is chosen.
- R7: The age order changes only when a thread is selected, and the selected thread becomes the most recently used. Cycles with `sel_valid` low leave the order as it was.
- R8: `sel_valid` is 0 in cycle t+1 only when no thread was selectable in cycle t.
- R9: When a miss wait and a long-latency block overlap on one thread, the thread stays out until both have ended.
- R10: With all threads ready, no misses and no long-latency issues, the selection rotates 0, 1, 2, 3, 0, and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready | input | NTHR | Thread has an instruction available |
| miss_start | input | NTHR | Pulse: thread begins waiting on a cache miss |
| miss_done | input | NTHR | Pulse: the thread's miss has been serviced |
| issue_long | input | 1 | The instruction issued this cycle for the shown thread is a load or a branch |
| sel_oh | output | NTHR | Registered one-hot selected thread |
| sel_valid | output | 1 | Registered: a thread is selected this cycle |

## Verification
A wrong age rank shows up on the first cycle in which two or more threads compete: the wrong thread appears on `sel_oh`. A rank that was never updated makes the rotation drift within one lap of the threads. A block counter that is stuck or off by one either shows a blocked thread too early or holds it out one cycle too long, and this is visible within four cycles of the long-latency issue. A miss flag that sticks or is lost shows at the first cycle after the done or start pulse in which that thread would otherwise win. The bench model follows these effects on every cycle, under directed patterns and under long random traffic.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;
  localparam int unsigned DEF_NTHR      = 4;
  localparam int unsigned DEF_BLOCK_CYC = 3;
endpackage

// File: rtl/thr_stall.sv
module thr_stall #(
  parameter int unsigned BLOCK_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ready,
  input  logic miss_start,
  input  logic miss_done,
  input  logic issued_long,
  output logic eligible
);
  localparam int unsigned CW = $clog2(BLOCK_CYC + 1);

  logic [CW-1:0] blk_cnt;
  logic          wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_cnt <= '0;
    end else if (issued_long) begin
      blk_cnt <= CW'(BLOCK_CYC - 1);
    end else if (blk_cnt != '0) begin
      blk_cnt <= blk_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= 1'b0;
    end else if (miss_start) begin
      wait_q <= 1'b1;
    end else if (miss_done) begin
      wait_q <= 1'b0;
    end
  end

  assign eligible = ready && !wait_q && !miss_start && (blk_cnt == '0) && !issued_long;

  // R4: once a miss opens, the thread stays out until it is closed
  p_miss_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (wait_q && !miss_done) |=> !eligible);

  // R5 / R9: a long issue keeps the thread out on the following cycle
  p_block_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (issued_long && BLOCK_CYC > 1) |=> !eligible);
endmodule

// File: rtl/lru_pick.sv
module lru_pick #(
  parameter int unsigned NTHR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTHR-1:0] elig,
  output logic [NTHR-1:0] pick_oh,
  output logic            any
);
  localparam int unsigned RW = (NTHR > 1) ? $clog2(NTHR) : 1;

  logic [RW-1:0]      rank [NTHR];
  logic [RW-1:0]      best_rank;
  logic [RW-1:0]      best_idx;
  logic               found;
  logic [NTHR*RW-1:0] rank_flat;
  logic [NTHR-1:0]    present;

  always_comb begin
    found     = 1'b0;
    best_rank = '0;
    best_idx  = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (elig[i] && (!found || rank[i] < best_rank)) begin
        found     = 1'b1;
        best_rank = rank[i];
        best_idx  = RW'(i);
      end
    end
    for (int i = 0; i < NTHR; i++) begin
      pick_oh[i] = found && (best_idx == RW'(i));
    end
  end

  assign any = found;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NTHR; i++) begin
      if (rst) begin
        rank[i] <= RW'(i);
      end else if (found) begin
        if (pick_oh[i]) begin
          rank[i] <= RW'(NTHR - 1);
        end else if (rank[i] > best_rank) begin
          rank[i] <= rank[i] - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_flat
    assign rank_flat[g*RW +: RW] = rank[g];
  end

  always_comb begin
    present = '0;
    for (int i = 0; i < NTHR; i++) begin
      present[rank[i]] = 1'b1;
    end
  end

  // R6: ranks always form a permutation, so the oldest is unique
  p_rank_perm_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(present) == NTHR);

  // R7: no selection, no change of order
  p_order_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !found |=> $stable(rank_flat));
endmodule

// File: rtl/thread_sched.sv
module thread_sched
  import thread_sched_pkg::*;
#(
  parameter int unsigned NTHR      = DEF_NTHR,
  parameter int unsigned BLOCK_CYC = DEF_BLOCK_CYC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTHR-1:0] thr_ready,
  input  logic [NTHR-1:0] miss_start,
  input  logic [NTHR-1:0] miss_done,
  input  logic            issue_long,
  output logic [NTHR-1:0] sel_oh,
  output logic            sel_valid
);
  logic [NTHR-1:0] elig;
  logic [NTHR-1:0] pick_oh;
  logic            pick_any;
  logic [NTHR-1:0] sel_q;
  logic            vld_q;

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    thr_stall #(.BLOCK_CYC(BLOCK_CYC)) u_stall (
      .clk        (clk),
      .rst        (rst),
      .ready      (thr_ready[g]),
      .miss_start (miss_start[g]),
      .miss_done  (miss_done[g]),
      .issued_long(issue_long && sel_q[g]),
      .eligible   (elig[g])
    );

    // R5: a long issue hides the thread on the next output
    p_long_skip_r5: assert property (@(posedge clk) disable iff (rst)
      (sel_q[g] && issue_long) |=> !sel_q[g]);

    // R4: a miss start hides the thread on the next output
    p_miss_skip_r4: assert property (@(posedge clk) disable iff (rst)
      miss_start[g] |=> !sel_q[g]);

    // R3: a thread not ready is never picked
    p_ready_only_r3: assert property (@(posedge clk) disable iff (rst)
      !thr_ready[g] |=> !sel_q[g]);
  end

  lru_pick #(.NTHR(NTHR)) u_lru (
    .clk    (clk),
    .rst    (rst),
    .elig   (elig),
    .pick_oh(pick_oh),
    .any    (pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sel_q <= pick_oh;
      vld_q <= pick_any;
    end
  end

  assign sel_oh    = sel_q;
  assign sel_valid = vld_q;

  // R2: one-hot output consistent with valid
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q) && (vld_q == (sel_q != '0)));

  // R8: idle only when nothing could go
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld_q == $past(elig != '0)));
endmodule

// File: tb/thread_sched_tb.sv
module thread_sched_tb;
  localparam int NT  = 4;
  localparam int BLK = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NT-1:0] thr_ready = '0;
  logic [NT-1:0] miss_start = '0;
  logic [NT-1:0] miss_done = '0;
  logic          issue_long = 1'b0;
  logic [NT-1:0] sel_oh;
  logic          sel_valid;

  int n_checks = 0;
  int n_fail   = 0;
  string tag = "R1";
  bit done_run = 0;

  // reference model state
  int lru_q[$];
  int cnt[NT];
  bit waitf[NT];
  bit exp_valid;
  int exp_sel;
  int pick;
  bit el[NT];

  always #5 clk = ~clk;

  thread_sched u_dut (
    .clk(clk), .rst(rst), .thr_ready(thr_ready), .miss_start(miss_start),
    .miss_done(miss_done), .issue_long(issue_long),
    .sel_oh(sel_oh), .sel_valid(sel_valid)
  );

  always @(posedge clk) begin
    if (rst) begin
      lru_q = {0, 1, 2, 3};
      for (int i = 0; i < NT; i++) begin cnt[i] = 0; waitf[i] = 0; end
      exp_valid = 0;
      exp_sel = 0;
    end else begin
      for (int i = 0; i < NT; i++) begin
        el[i] = thr_ready[i] && !waitf[i] && !miss_start[i] && cnt[i] == 0 &&
                !(exp_valid && exp_sel == i && issue_long);
      end
      pick = -1;
      for (int k = 0; k < lru_q.size(); k++) begin
        if (pick < 0 && el[lru_q[k]]) pick = lru_q[k];
      end
      for (int i = 0; i < NT; i++) begin
        if (exp_valid && exp_sel == i && issue_long) cnt[i] = BLK - 1;
        else if (cnt[i] > 0) cnt[i] = cnt[i] - 1;
        if (miss_start[i]) waitf[i] = 1;
        else if (miss_done[i]) waitf[i] = 0;
      end
      if (pick >= 0) begin
        for (int k = 0; k < lru_q.size(); k++) begin
          if (lru_q[k] == pick) begin lru_q.delete(k); break; end
        end
        lru_q.push_back(pick);
        exp_valid = 1;
        exp_sel = pick;
      end else begin
        exp_valid = 0;
      end
    end
  end

  task automatic compare();
    logic [NT-1:0] e_oh;
    e_oh = exp_valid ? (NT'(1) << exp_sel) : '0;
    n_checks++;
    if (sel_oh !== e_oh || sel_valid !== exp_valid) begin
      n_fail++;
      $display("FAIL %s: sel_oh=%b valid=%b expected sel_oh=%b valid=%b at %0t",
               tag, sel_oh, sel_valid, e_oh, exp_valid, $time);
    end
  endtask

  task automatic step(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare();
      miss_start = '0;
      miss_done  = '0;
      issue_long = 1'b0;
    end
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    n_checks++;
    if (sel_oh !== '0 || sel_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: sel_oh=%b valid=%b expected 0000/0", sel_oh, sel_valid);
    end
    rst = 1'b0;
    thr_ready = '1;
    step(1);
    // R10: rotation, first pick thread 0 (R1)
    tag = "R10";
    step(9);
    // R3: some threads not ready
    tag = "R3";
    thr_ready = 4'b0101;
    step(6);
    thr_ready = '1;
    // R5: long issue on the shown thread
    tag = "R5";
    issue_long = 1'b1;
    step(6);
    thr_ready = 4'b0010;
    step(1);
    issue_long = 1'b1;
    step(6);
    thr_ready = '1;
    // R4: miss wait
    tag = "R4";
    miss_start = 4'b0010;
    step(5);
    miss_done = 4'b0010;
    step(4);
    miss_start = 4'b0100;
    miss_done  = 4'b0100;
    step(5);
    miss_done = 4'b0100;
    step(3);
    // R9: overlap of miss and block
    tag = "R9";
    thr_ready = 4'b0001;
    step(2);
    issue_long = 1'b1;
    miss_start = 4'b0001;
    step(1);
    miss_done = 4'b0001;
    step(6);
    issue_long = 1'b1;
    miss_start = 4'b0001;
    step(4);
    miss_done = 4'b0001;
    step(4);
    // R8 / R7: idle keeps order
    tag = "R8";
    thr_ready = '0;
    step(4);
    tag = "R7";
    thr_ready = '1;
    step(6);
    // R6: random traffic
    tag = "R6";
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      compare();
      thr_ready = NT'($urandom);
      for (int i = 0; i < NT; i++) begin
        miss_start[i] = ($urandom_range(0, 7) == 0);
        miss_done[i]  = ($urandom_range(0, 3) == 0);
      end
      issue_long = $urandom_range(0, 1) == 1;
    end
    done_run = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule